// File: doc/BRIEF.md
# Programmable Event Timer Channel

This block is one 16-bit timer channel on a simple single-cycle register bus. A slow tick strobe, synchronous to the bus clock, drives a prescaler. Each time the prescaler wraps, the counter takes one step, either up or down. A three-bit completion field sets what happens next. The counter can stop when it reaches zero. It can reload its stored start value when it meets a chosen compare register. It can also run without end and wrap through the full 16-bit range.

There are six compare registers, and each one has its own sticky status bit. A status bit is set when a count step lands the counter on that compare value. Software clears a status bit by writing a one to it. The status bits are ANDed with a mask and then ORed together to form a single interrupt line. Writes take effect on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`.

Top module: `evtimer_top`

## Requirements
- R1: After reset the registers read as follows: count 0, divider 0, control 0x10 (frozen), status 0, mask 0, and every compare 0xFFFF. The irq output is low.
- R2: A write to the count register (address 0) loads the counter at once and also stores the value as the reload value.
- R3: The divider register (address 1) holds ticks-per-step minus one. With divider N, the counter steps on every (N+1)-th tick cycle. Cycles where `tick` is low do not advance the prescaler.
- R4: Control (address 2) bit 4 = 1 freezes both the counter and the prescaler. Ticks have no effect while this bit is set.
- R5: Control bit 3 sets the direction: 1 counts up and 0 counts down.
- R6: Control bits 2..0 = 0 selects stop-at-zero. The counter moves toward zero and then holds at 0 with no wrap.
- R7: Control bits 2..0 = m, with m from 1 to 6, selects reload mode. On a step where the counter equals compare m, the counter reloads the stored value instead of advancing.
- R8: Control bits 2..0 = 7 selects free-run. The counter wraps, so counting down from 0 gives 0xFFFF and counting up from 0xFFFF gives 0.
- R9: Compare register k+1 sits at address 4+k+1 (addresses 5 to 10). Status bit k is set when a count step moves the counter to a value equal to compare k+1.
- R10: Status (address 3) is write-one-to-clear on bits 5..0. If a set and a clear reach the same bit in the same cycle, the bit ends up set.
- R11: irq is high exactly when status AND mask (address 4, bits 5..0) is nonzero.
- R12: A write to the divider or the count register restarts the prescaler from zero.
- R13: Every register reads back at its address through `bus_rdata`. Unused upper bits read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle slow tick enable |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| irq | output | 1 | Masked interrupt request |

## Verification
The assertions assume that `tick` and `bus_wr` are clean one-cycle levels sampled at the rising edge. They also assume that the divider changes only through a bus write, which always restarts the prescaler. That keeps the prescaler count at or below the divider. The stimulus changes inputs one time unit after a rising edge and samples outputs at the falling edge. The only deliberate overlap of a count step and a bus write is the set-versus-clear case on the status register.

// File: rtl/evtimer_pkg.sv
package evtimer_pkg;
    localparam int CNT_W    = 16;
    localparam int N_CMP    = 6;
    localparam int ADDR_W   = 4;

    localparam logic [ADDR_W-1:0] A_COUNT = 4'd0;
    localparam logic [ADDR_W-1:0] A_DIV   = 4'd1;
    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd2;
    localparam logic [ADDR_W-1:0] A_STAT  = 4'd3;
    localparam logic [ADDR_W-1:0] A_MASK  = 4'd4;
    localparam logic [ADDR_W-1:0] A_CMP0  = 4'd5;

    localparam logic [2:0] MODE_ZERO = 3'd0;
    localparam logic [2:0] MODE_FREE = 3'd7;

    typedef struct packed {
        logic       freeze;
        logic       up;
        logic [2:0] mode;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/evtimer_prescale.sv
module evtimer_prescale
    import evtimer_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         run,
    input  logic         restart,
    input  logic [W-1:0] div,
    output logic         step
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } pre_t;

    pre_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        step = 1'b0;
        if (restart) begin
            st_d.cnt = '0;
        end else if (tick && run) begin
            if (st_q.cnt == div) begin
                st_d.cnt = '0;
                step     = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R12: a register write restarts the tick count
    a_r12_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.cnt == '0));
    // R3: the tick count never passes the divider
    a_r3_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= div);
    // R4: no ticks counted while frozen
    a_r4_pre_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(st_q.cnt));
endmodule

// File: rtl/evtimer_count.sv
module evtimer_count
    import evtimer_pkg::*;
#(
    parameter int W    = CNT_W,
    parameter int NCMP = N_CMP
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step,
    input  logic                     load,
    input  logic [W-1:0]             load_val,
    input  ctrl_t                    ctrl,
    input  logic [NCMP-1:0][W-1:0]   cmp,
    output logic [W-1:0]             value,
    output logic [NCMP-1:0]          match
);
    typedef struct packed {
        logic [W-1:0] value;
        logic [W-1:0] reload;
    } cnt_t;

    cnt_t st_d, st_q;
    logic [W-1:0] adv;
    logic [W-1:0] nxt;
    logic         sel_hit;

    always_comb begin
        adv     = ctrl.up ? st_q.value + 1'b1 : st_q.value - 1'b1;
        sel_hit = 1'b0;
        for (int k = 0; k < NCMP; k++) begin
            if (ctrl.mode == 3'(k + 1) && st_q.value == cmp[k]) sel_hit = 1'b1;
        end
        if (ctrl.mode == MODE_ZERO) begin
            nxt = (st_q.value == '0) ? '0 : adv;
        end else if (ctrl.mode == MODE_FREE || int'(ctrl.mode) > NCMP) begin
            nxt = adv;
        end else begin
            nxt = sel_hit ? st_q.reload : adv;
        end

        st_d = st_q;
        if (load) begin
            st_d.value  = load_val;
            st_d.reload = load_val;
        end else if (step) begin
            st_d.value = nxt;
        end
    end

    generate
        for (genvar k = 0; k < NCMP; k++) begin : g_match
            assign match[k] = step && !load && (nxt == cmp[k]);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value = st_q.value;

    // R6: stop-at-zero never leaves zero without a load
    a_r6_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.mode == MODE_ZERO && st_q.value == '0 && !load) |=> (st_q.value == '0));
    // R4: frozen counter keeps its value
    a_r4_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.freeze && !load) |=> $stable(st_q.value));
    // R2: a load shows up in the counter next cycle
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st_q.value == $past(load_val)));
endmodule

// File: rtl/evtimer_irq.sv
module evtimer_irq
    import evtimer_pkg::*;
#(
    parameter int NCMP = N_CMP
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCMP-1:0] match,
    input  logic [NCMP-1:0] clr,
    input  logic [NCMP-1:0] mask,
    output logic [NCMP-1:0] status,
    output logic            irq
);
    typedef struct packed {
        logic [NCMP-1:0] stat;
    } irq_t;

    irq_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.stat = (st_q.stat & ~clr) | match;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.stat;
    assign irq    = |(st_q.stat & mask);

    // R10: a match wins over a same-cycle clear
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (match != '0) |=> ((st_q.stat & $past(match)) == $past(match)));
    // R10: a clear without a match empties the bit
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr & ~match) != '0) |=> ((st_q.stat & $past(clr & ~match)) == '0));
endmodule

// File: rtl/evtimer_top.sv
module evtimer_top
    import evtimer_pkg::*;
#(
    parameter int W    = CNT_W,
    parameter int NCMP = N_CMP,
    parameter int AW   = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    output logic          irq
);
    typedef struct packed {
        logic [W-1:0]             div;
        ctrl_t                    ctrl;
        logic [NCMP-1:0]          mask;
        logic [NCMP-1:0][W-1:0]   cmp;
    } regs_t;

    regs_t rg_d, rg_q;

    logic            wr_count, wr_div, wr_stat;
    logic            step;
    logic [W-1:0]    value;
    logic [NCMP-1:0] match, clr, status;

    assign wr_count = bus_wr && (bus_addr == A_COUNT);
    assign wr_div   = bus_wr && (bus_addr == A_DIV);
    assign wr_stat  = bus_wr && (bus_addr == A_STAT);
    assign clr      = wr_stat ? bus_wdata[NCMP-1:0] : '0;

    always_comb begin
        rg_d = rg_q;
        if (bus_wr) begin
            if (bus_addr == A_DIV)  rg_d.div  = bus_wdata;
            if (bus_addr == A_CTRL) rg_d.ctrl = ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (bus_addr == A_MASK) rg_d.mask = bus_wdata[NCMP-1:0];
            for (int k = 0; k < NCMP; k++) begin
                if (bus_addr == A_CMP0 + AW'(k)) rg_d.cmp[k] = bus_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q             <= '0;
            rg_q.ctrl.freeze <= 1'b1;
            rg_q.cmp         <= '1;
        end else begin
            rg_q <= rg_d;
        end
    end

    evtimer_prescale #(.W(W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .run     (!rg_q.ctrl.freeze),
        .restart (wr_count || wr_div),
        .div     (rg_q.div),
        .step    (step)
    );

    evtimer_count #(.W(W), .NCMP(NCMP)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .load     (wr_count),
        .load_val (bus_wdata),
        .ctrl     (rg_q.ctrl),
        .cmp      (rg_q.cmp),
        .value    (value),
        .match    (match)
    );

    evtimer_irq #(.NCMP(NCMP)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .match  (match),
        .clr    (clr),
        .mask   (rg_q.mask),
        .status (status),
        .irq    (irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_COUNT: bus_rdata = value;
            A_DIV:   bus_rdata = rg_q.div;
            A_CTRL:  bus_rdata = {{(W-CTRL_W){1'b0}}, rg_q.ctrl};
            A_STAT:  bus_rdata = {{(W-NCMP){1'b0}}, status};
            A_MASK:  bus_rdata = {{(W-NCMP){1'b0}}, rg_q.mask};
            default: begin
                for (int k = 0; k < NCMP; k++) begin
                    if (bus_addr == A_CMP0 + AW'(k)) bus_rdata = rg_q.cmp[k];
                end
            end
        endcase
    end

    // R11: interrupt only with a masked status bit
    a_r11_irq_src: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((status & rg_q.mask) != '0));
endmodule

// File: tb/evtimer_top_test.sv
module evtimer_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [3:0]  addr;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];

    always #2.5 clk = ~clk;

    evtimer_top uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    // monitor: compares queued expectations away from the rising edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it = sb.pop_front();
                act = it.is_irq ? {15'd0, irq} : bus_rdata;
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.addr, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1; tick = 1'b1;
            @(posedge clk); #1; tick = 1'b0;
        end
    endtask

    task automatic expect_reg(input logic [3:0] a, input logic [15:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        bus_addr = a;
        it.is_irq = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(negedge clk); #2;
    endtask

    task automatic expect_irq(input logic e, input string tag);
        item_t it;
        @(posedge clk); #1;
        it.is_irq = 1'b1; it.addr = 4'd0; it.exp = {15'd0, e}; it.tag = tag;
        sb.push_back(it);
        @(negedge clk); #2;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        expect_reg(4'd0, 16'h0000, "R1 count");
        expect_reg(4'd1, 16'h0000, "R1 div");
        expect_reg(4'd2, 16'h0010, "R1 ctrl");
        expect_reg(4'd3, 16'h0000, "R1 status");
        expect_reg(4'd5, 16'hFFFF, "R1 cmp1");
        expect_irq(1'b0, "R1 irq");

        // R2 R5 down count in free run
        wr(4'd0, 16'd5);
        wr(4'd2, 16'h0007);
        ticks(1);
        expect_reg(4'd0, 16'd4, "R5 down step");
        ticks(2);
        expect_reg(4'd0, 16'd2, "R2 R5 down two");

        // R3 R5 divider with up count
        wr(4'd1, 16'd2);
        wr(4'd0, 16'd100);
        wr(4'd2, 16'h000F);
        expect_reg(4'd1, 16'd2, "R13 div readback");
        ticks(2);
        expect_reg(4'd0, 16'd100, "R3 before third tick");
        ticks(1);
        expect_reg(4'd0, 16'd101, "R3 third tick");
        ticks(3);
        expect_reg(4'd0, 16'd102, "R3 next period");

        // R4 freeze
        wr(4'd2, 16'h001F);
        expect_reg(4'd2, 16'h001F, "R13 ctrl readback");
        ticks(5);
        expect_reg(4'd0, 16'd102, "R4 frozen");

        // R6 stop at zero, counting down
        wr(4'd1, 16'd0);
        wr(4'd0, 16'd3);
        wr(4'd2, 16'h0000);
        ticks(3);
        expect_reg(4'd0, 16'd0, "R6 reached zero");
        ticks(2);
        expect_reg(4'd0, 16'd0, "R6 holds zero");

        // R8 wrap, R9 all compares at 0xFFFF
        wr(4'd0, 16'd1);
        wr(4'd2, 16'h0007);
        ticks(2);
        expect_reg(4'd0, 16'hFFFF, "R8 wrap down");
        expect_reg(4'd3, 16'h003F, "R9 all matched");
        expect_irq(1'b0, "R11 mask zero");
        wr(4'd3, 16'h0005);
        expect_reg(4'd3, 16'h003A, "R10 w1c partial");
        wr(4'd3, 16'h003A);
        expect_reg(4'd3, 16'h0000, "R10 w1c rest");

        // R7 reload on compare 2, up count
        wr(4'd6, 16'd10);
        expect_reg(4'd6, 16'd10, "R13 cmp2 readback");
        wr(4'd0, 16'd7);
        wr(4'd2, 16'h000A);
        ticks(3);
        expect_reg(4'd0, 16'd10, "R7 at compare");
        expect_reg(4'd3, 16'h0002, "R9 bit1");
        ticks(1);
        expect_reg(4'd0, 16'd7, "R7 R2 reload");

        // R11 mask
        wr(4'd4, 16'h0002);
        expect_irq(1'b1, "R11 masked on");
        wr(4'd4, 16'h0001);
        expect_irq(1'b0, "R11 other mask");
        wr(4'd4, 16'h0002);
        wr(4'd3, 16'h0002);
        expect_irq(1'b0, "R11 after clear");

        // R7 reload on compare 5, down count
        wr(4'd9, 16'd3);
        wr(4'd0, 16'd5);
        wr(4'd2, 16'h0005);
        ticks(2);
        expect_reg(4'd0, 16'd3, "R7 down at compare");
        expect_reg(4'd3, 16'h0010, "R9 bit4");
        ticks(1);
        expect_reg(4'd0, 16'd5, "R7 down reload");

        // R10 set wins over same-cycle clear
        wr(4'd5, 16'd10);
        wr(4'd3, 16'h003F);
        wr(4'd0, 16'd9);
        wr(4'd2, 16'h000F);
        @(posedge clk); #1;
        tick = 1'b1; bus_wr = 1'b1; bus_addr = 4'd3; bus_wdata = 16'h0001;
        @(posedge clk); #1;
        tick = 1'b0; bus_wr = 1'b0;
        expect_reg(4'd0, 16'd10, "R10 step taken");
        expect_reg(4'd3, 16'h0003, "R10 set wins");

        // R12 prescaler restart on divider write
        wr(4'd1, 16'd3);
        wr(4'd0, 16'd20);
        ticks(2);
        wr(4'd1, 16'd3);
        ticks(3);
        expect_reg(4'd0, 16'd20, "R12 restarted");
        ticks(1);
        expect_reg(4'd0, 16'd21, "R12 step after restart");

        // R6 stop at zero counting up through wrap, R8 up wrap free
        wr(4'd1, 16'd0);
        wr(4'd0, 16'hFFFE);
        wr(4'd2, 16'h0008);
        ticks(1);
        expect_reg(4'd0, 16'hFFFF, "R6 up step");
        ticks(1);
        expect_reg(4'd0, 16'h0000, "R6 up reaches zero");
        ticks(1);
        expect_reg(4'd0, 16'h0000, "R6 up holds");
        wr(4'd0, 16'hFFFF);
        wr(4'd2, 16'h000F);
        ticks(1);
        expect_reg(4'd0, 16'h0000, "R8 wrap up");
        expect_reg(4'd7, 16'hFFFF, "R13 cmp3 readback");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule